// File: doc/BRIEF.md
# Completion Interrupt Delay Timer Pair

This block paces completion interrupts for one descriptor ring. It holds two countdown timers that run in units of an external interrupt timebase tick. The packet delay timer is reloaded by every qualifying packet completion, so under a steady stream it keeps moving the interrupt later. The absolute delay timer is armed by the first qualifying completion and then left alone, so it caps how long a completion can wait. Whichever timer runs out first raises a one-cycle timer-cause pulse toward the interrupt controller and both timers stop.

Software sets both delays through two 16-bit configuration registers. A zero packet delay disables all timer activity, leaving pacing to an interrupt throttle elsewhere. On the transmit variant only completions whose descriptor asked for a delayed interrupt are counted. A flush request, or the interrupt controller taking the pending cause by another route, cancels both timers quietly.

Top module: `ivt_delay_timers`

## Requirements
- R1: After reset both timers are idle (`pkt_tmr_run` and `abs_tmr_run` low), `cause_pulse` is low and both delay registers read as zero.
- R2: A qualifying completion with a nonzero packet delay D starts the packet timer; if nothing else happens, `cause_pulse` is high right after the edge of the D-th later cycle that has `tmr_tick` high.
- R3: A qualifying completion while the packet timer runs reloads it with the full packet delay, so the pulse comes D ticks after the last completion.
- R4: The absolute timer starts on a qualifying completion only when both the absolute delay and the packet delay are nonzero.
- R5: A completion does not reload a running absolute timer; with absolute delay A it expires A ticks after the completion that started it, even while completions keep reloading the packet timer.
- R6: With `IS_TX` = 1 (default) a completion counts only when `pkt_delay_req` is high in the same cycle; completions with it low leave both timers unchanged.
- R7: When the packet delay is zero, completions start neither timer and no pulse results.
- R8: When either timer expires, `cause_pulse` is high for the following cycle and both timers stop, unless a completion in the expiry cycle starts them again.
- R9: `flush_req` or `post_taken` high in a cycle stops both timers and suppresses any pulse that would have come from that cycle, including an expiry in the same cycle.
- R10: Writing a delay register does not change a running timer; the next start uses the new value. A completion in the same cycle as a write uses the old value.
- R11: A `tmr_tick` in the cycle a timer is (re)loaded does not count down; a packet timer reload in its own expiry cycle cancels that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_tick | input | 1 | One-cycle strobe of the interrupt timebase |
| pkt_done | input | 1 | One-cycle packet completion strobe |
| pkt_delay_req | input | 1 | Completion asks for a delayed interrupt (used when `IS_TX` = 1) |
| cfg_wdata | input | DW | Write data for the delay registers, in timebase ticks |
| cfg_pkt_we | input | 1 | Write strobe of the packet delay register |
| cfg_abs_we | input | 1 | Write strobe of the absolute delay register |
| flush_req | input | 1 | Cancel both timers without a pulse |
| post_taken | input | 1 | Pending cause was consumed elsewhere; cancel both timers |
| cause_pulse | output | 1 | One-cycle timer-cause pulse to the interrupt controller |
| pkt_tmr_run | output | 1 | Packet delay timer running |
| abs_tmr_run | output | 1 | Absolute delay timer running |

## Verification
The hardest situations to reach are the coincidences: an expiry in the same cycle as a flush, a completion or a delay write, and the absolute timer running out while the packet timer is still being pushed back. The bench reaches them by counting ticks from a known start, issuing completions every other cycle with a packet delay longer than that gap, and lining a flush or a completion up with the known expiry tick. A long run of random strobes with small delays then lets a behavioural model catch any other alignment on every clock.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  // Default width of the delay registers and counters, in timebase ticks.
  localparam int IVT_DLY_W = 16;

  // How a timer treats a start request while it is already counting.
  typedef enum logic {
    RELOAD_ALWAYS = 1'b0,  // restart from the full value
    HOLD_RUNNING  = 1'b1   // ignore the request until idle
  } ivt_policy_e;

endpackage

// File: rtl/ivt_countdown.sv
module ivt_countdown
  import ivt_pkg::*;
#(
  parameter int          DW     = IVT_DLY_W,
  parameter ivt_policy_e POLICY = RELOAD_ALWAYS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          kill,
  input  logic          stop,
  output logic          running,
  output logic          expire
);

  localparam logic [DW-1:0] ONE = DW'(1);

  function automatic logic at_last(input logic [DW-1:0] c);
    return c == ONE;
  endfunction

  function automatic logic [DW-1:0] step_down(input logic [DW-1:0] c);
    return c - ONE;
  endfunction

  logic          run_q;
  logic [DW-1:0] cnt_q;
  logic          accept;
  logic          reload_hides_expiry;

  generate
    if (POLICY == RELOAD_ALWAYS) begin : g_reload
      assign accept              = load;
      assign reload_hides_expiry = load;
    end else begin : g_hold
      assign accept              = load && (!run_q || stop);
      assign reload_hides_expiry = 1'b0;
    end
  endgenerate

  assign expire  = run_q && tick && at_last(cnt_q) && !kill && !reload_hides_expiry;
  assign running = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (kill) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (accept) begin
      run_q <= 1'b1;
      cnt_q <= load_val;
    end else if (stop) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick && run_q) begin
      cnt_q <= step_down(cnt_q);
    end
  end

  // R2: a start is only ever requested with a nonzero delay
  a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

  // R9: a cancel leaves the timer idle
  a_r9_kill_idles: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !run_q);

  generate
    if (POLICY == RELOAD_ALWAYS) begin : g_chk_reload
      // R3: every start restarts from the full value
      a_r3_full_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load && !kill |=> run_q && (cnt_q == $past(load_val)));
    end else begin : g_chk_hold
      // R5: a running timer only counts down until it is stopped
      a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !stop && !kill |=>
          run_q && (cnt_q == $past(cnt_q) - DW'($past(tick))));
    end
  endgenerate

endmodule

// File: rtl/ivt_qualify.sv
module ivt_qualify #(
  parameter int DW    = 16,
  parameter bit IS_TX = 1'b1
) (
  input  logic          pkt_done,
  input  logic          pkt_delay_req,
  input  logic [DW-1:0] pkt_dly,
  input  logic [DW-1:0] abs_dly,
  output logic          done_ok,
  output logic          pkt_load,
  output logic          abs_load
);

  function automatic logic nonzero(input logic [DW-1:0] v);
    return |v;
  endfunction

  generate
    if (IS_TX) begin : g_tx
      assign done_ok = pkt_done && pkt_delay_req;
    end else begin : g_rx
      logic unused_req;
      assign unused_req = pkt_delay_req;
      assign done_ok    = pkt_done;
    end
  endgenerate

  assign pkt_load = done_ok && nonzero(pkt_dly);
  assign abs_load = pkt_load && nonzero(abs_dly);

endmodule

// File: rtl/ivt_delay_timers.sv
module ivt_delay_timers
  import ivt_pkg::*;
#(
  parameter int DW    = IVT_DLY_W,
  parameter bit IS_TX = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_tick,
  input  logic          pkt_done,
  input  logic          pkt_delay_req,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          cfg_pkt_we,
  input  logic          cfg_abs_we,
  input  logic          flush_req,
  input  logic          post_taken,
  output logic          cause_pulse,
  output logic          pkt_tmr_run,
  output logic          abs_tmr_run
);

  logic [DW-1:0] pkt_dly_q;
  logic [DW-1:0] abs_dly_q;
  logic          done_ok;
  logic          pkt_load;
  logic          abs_load;
  logic          kill;
  logic          pkt_expire;
  logic          abs_expire;
  logic          expire_any;
  logic          cause_q;

  // delay registers: a write only affects later starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_dly_q <= '0;
      abs_dly_q <= '0;
    end else begin
      if (cfg_pkt_we) pkt_dly_q <= cfg_wdata;
      if (cfg_abs_we) abs_dly_q <= cfg_wdata;
    end
  end

  ivt_qualify #(.DW(DW), .IS_TX(IS_TX)) u_qual (
    .pkt_done      (pkt_done),
    .pkt_delay_req (pkt_delay_req),
    .pkt_dly       (pkt_dly_q),
    .abs_dly       (abs_dly_q),
    .done_ok       (done_ok),
    .pkt_load      (pkt_load),
    .abs_load      (abs_load)
  );

  assign kill       = flush_req || post_taken;
  assign expire_any = pkt_expire || abs_expire;

  ivt_countdown #(.DW(DW), .POLICY(RELOAD_ALWAYS)) u_pkt_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tmr_tick),
    .load     (pkt_load),
    .load_val (pkt_dly_q),
    .kill     (kill),
    .stop     (expire_any),
    .running  (pkt_tmr_run),
    .expire   (pkt_expire)
  );

  ivt_countdown #(.DW(DW), .POLICY(HOLD_RUNNING)) u_abs_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tmr_tick),
    .load     (abs_load),
    .load_val (abs_dly_q),
    .kill     (kill),
    .stop     (expire_any),
    .running  (abs_tmr_run),
    .expire   (abs_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= 1'b0;
    else        cause_q <= expire_any;
  end

  assign cause_pulse = cause_q;

  // R9: a cancel gives no pulse and leaves both timers idle
  a_r9_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !cause_pulse && !pkt_tmr_run && !abs_tmr_run);

  // R8: an expiry without a fresh completion pulses once and stops both
  a_r8_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
    expire_any && !done_ok |=> cause_pulse && !pkt_tmr_run && !abs_tmr_run);

  // R7: a zero packet delay never wakes an idle pair
  a_r7_zero_delay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_dly_q == '0) && !pkt_tmr_run && !abs_tmr_run |=> !pkt_tmr_run && !abs_tmr_run);

  // R4: the absolute timer never starts without the packet timer
  a_r4_abs_with_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abs_tmr_run) |-> pkt_tmr_run);

  // R6: ignored completions keep idle timers idle
  a_r6_ignored_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ok && !pkt_tmr_run && !abs_tmr_run |=> !pkt_tmr_run && !abs_tmr_run);

endmodule

// File: tb/ivt_delay_timers_test.sv
module ivt_delay_timers_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tmr_tick = 1'b0;
  logic          pkt_done = 1'b0;
  logic          pkt_delay_req = 1'b0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          cfg_pkt_we = 1'b0;
  logic          cfg_abs_we = 1'b0;
  logic          flush_req = 1'b0;
  logic          post_taken = 1'b0;
  logic          cause_pulse, pkt_tmr_run, abs_tmr_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivt_delay_timers #(.DW(DW), .IS_TX(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .pkt_done(pkt_done),
    .pkt_delay_req(pkt_delay_req), .cfg_wdata(cfg_wdata),
    .cfg_pkt_we(cfg_pkt_we), .cfg_abs_we(cfg_abs_we),
    .flush_req(flush_req), .post_taken(post_taken),
    .cause_pulse(cause_pulse), .pkt_tmr_run(pkt_tmr_run), .abs_tmr_run(abs_tmr_run)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    cmp_on = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_pd = 0, m_ad = 0, m_pc = 0, m_ac = 0;
  bit m_pr = 0, m_ar = 0, m_cause = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pd = 0; m_ad = 0; m_pc = 0; m_ac = 0;
      m_pr = 0; m_ar = 0; m_cause = 0;
    end else begin
      bit ok, kl, start_p, start_a, end_p, end_a, halt;
      ok      = pkt_done && pkt_delay_req;
      kl      = flush_req || post_taken;
      start_p = ok && (m_pd != 0);
      start_a = start_p && (m_ad != 0);
      end_p   = m_pr && tmr_tick && (m_pc == 1) && !kl && !start_p;
      end_a   = m_ar && tmr_tick && (m_ac == 1) && !kl;
      halt    = end_p || end_a;
      if (kl) begin m_pr = 0; m_pc = 0; end
      else if (start_p) begin m_pr = 1; m_pc = m_pd; end
      else if (halt) begin m_pr = 0; m_pc = 0; end
      else if (tmr_tick && m_pr) m_pc = m_pc - 1;
      if (kl) begin m_ar = 0; m_ac = 0; end
      else if (start_a && (!m_ar || halt)) begin m_ar = 1; m_ac = m_ad; end
      else if (halt) begin m_ar = 0; m_ac = 0; end
      else if (tmr_tick && m_ar) m_ac = m_ac - 1;
      m_cause = halt;
      if (cfg_pkt_we) m_pd = int'(cfg_wdata);
      if (cfg_abs_we) m_ad = int'(cfg_wdata);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(cur_req, "model cause_pulse", int'(cause_pulse), int'(m_cause));
      chk(cur_req, "model pkt_tmr_run", int'(pkt_tmr_run), int'(m_pr));
      chk(cur_req, "model abs_tmr_run", int'(abs_tmr_run), int'(m_ar));
    end
  end

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic go(input bit d, input bit r, input bit t, input bit f, input bit p);
    pkt_done = d; pkt_delay_req = r; tmr_tick = t; flush_req = f; post_taken = p;
    @(posedge clk); #1;
    pkt_done = 0; pkt_delay_req = 0; tmr_tick = 0; flush_req = 0; post_taken = 0;
  endtask

  task automatic wr(input bit to_abs, input int v);
    cfg_wdata = DW'(v); cfg_pkt_we = !to_abs; cfg_abs_we = to_abs;
    @(posedge clk); #1;
    cfg_pkt_we = 0; cfg_abs_we = 0;
  endtask

  task automatic ticks_to_pulse(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      go(0, 0, 1, 0, 0);
      n++;
      if (cause_pulse) break;
    end
  endtask

  int lat;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp_on = 1;
    // R1: reset state
    cur_req = "R1";
    chk("R1", "cause_pulse after reset", int'(cause_pulse), 0);
    chk("R1", "pkt_tmr_run after reset", int'(pkt_tmr_run), 0);
    chk("R1", "abs_tmr_run after reset", int'(abs_tmr_run), 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R7: zero delays, completion does nothing
    cur_req = "R7";
    go(1, 1, 1, 0, 0);
    repeat (3) go(0, 0, 1, 0, 0);
    chk("R7", "pkt_tmr_run with zero delay", int'(pkt_tmr_run), 0);
    chk("R7", "no pulse with zero delay", int'(cause_pulse), 0);

    // R2 / R11: packet timer, tick in the load cycle does not count
    cur_req = "R2";
    wr(0, 3);
    go(1, 1, 1, 0, 0);
    chk("R2", "pkt_tmr_run after start", int'(pkt_tmr_run), 1);
    ticks_to_pulse(lat);
    chk("R11", "ticks to pulse, delay 3", lat, 3);
    go(0, 0, 0, 0, 0);
    chk("R8", "pulse lasts one cycle", int'(cause_pulse), 0);

    // R3: restart from full value
    cur_req = "R3";
    wr(0, 4);
    go(1, 1, 0, 0, 0);
    go(0, 0, 1, 0, 0);
    go(0, 0, 1, 0, 0);
    go(1, 1, 0, 0, 0);
    ticks_to_pulse(lat);
    chk("R3", "ticks to pulse after reload", lat, 4);

    // R4: absolute needs both delays
    cur_req = "R4";
    wr(0, 0); wr(1, 5);
    go(1, 1, 0, 0, 0);
    chk("R4", "abs idle with zero packet delay", int'(abs_tmr_run), 0);
    wr(0, 2);
    go(1, 1, 0, 0, 0);
    chk("R4", "abs running with both delays", int'(abs_tmr_run), 1);
    go(0, 0, 0, 1, 0);

    // R5 / R8: absolute bound under steady completions
    cur_req = "R5";
    wr(0, 3); wr(1, 6);
    go(1, 1, 0, 0, 0);
    lat = 0;
    for (int i = 1; i <= 10; i++) begin
      go((i == 2) || (i == 4), 1, 1, 0, 0);
      lat++;
      if (cause_pulse) break;
    end
    chk("R5", "absolute expiry ticks", lat, 6);
    chk("R8", "pkt timer stopped on expiry", int'(pkt_tmr_run), 0);
    chk("R8", "abs timer stopped on expiry", int'(abs_tmr_run), 0);

    // R6: completions without delay request are ignored
    cur_req = "R6";
    go(1, 0, 0, 0, 0);
    chk("R6", "pkt timer idle without request", int'(pkt_tmr_run), 0);
    chk("R6", "abs timer idle without request", int'(abs_tmr_run), 0);

    // R9: flush and post cancel, including in the expiry cycle
    cur_req = "R9";
    go(1, 1, 0, 0, 0);
    go(0, 0, 1, 1, 0);
    chk("R9", "flush stops pkt timer", int'(pkt_tmr_run), 0);
    chk("R9", "flush stops abs timer", int'(abs_tmr_run), 0);
    go(1, 1, 0, 0, 0);
    go(0, 0, 0, 0, 1);
    chk("R9", "post stops pkt timer", int'(pkt_tmr_run), 0);
    wr(1, 0); wr(0, 1);
    go(1, 1, 0, 0, 0);
    go(0, 0, 1, 1, 0);
    chk("R9", "no pulse when flush meets expiry", int'(cause_pulse), 0);

    // R10: writes leave a running timer alone
    cur_req = "R10";
    wr(0, 4);
    go(1, 1, 0, 0, 0);
    wr(0, 1);
    ticks_to_pulse(lat);
    chk("R10", "running timer keeps old delay", lat, 4);
    go(1, 1, 0, 0, 0);
    ticks_to_pulse(lat);
    chk("R10", "next start uses new delay", lat, 1);

    // R11: reload in expiry cycle cancels that expiry
    cur_req = "R11";
    wr(0, 2);
    go(1, 1, 0, 0, 0);
    go(0, 0, 1, 0, 0);
    go(1, 1, 1, 0, 0);
    chk("R11", "reload hides expiry", int'(cause_pulse), 0);
    ticks_to_pulse(lat);
    chk("R11", "ticks after reload", lat, 2);

    // mixed random traffic against the model
    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      int rv;
      rv = int'($urandom_range(0, 99));
      cfg_wdata  = DW'($urandom_range(0, 6));
      cfg_pkt_we = (rv < 3);
      cfg_abs_we = (rv >= 3 && rv < 6);
      pkt_done      = ($urandom_range(0, 3) == 0);
      pkt_delay_req = ($urandom_range(0, 3) != 0);
      tmr_tick      = ($urandom_range(0, 1) == 0);
      flush_req     = (rv == 50);
      post_taken    = (rv == 51);
      @(posedge clk); #1;
    end
    cfg_pkt_we = 0; cfg_abs_we = 0; pkt_done = 0; tmr_tick = 0;
    flush_req = 0; post_taken = 0;
    @(posedge clk); #1;
    summary();
  end

endmodule